// File: doc/BRIEF.md
# RTC Alarm and Update Interrupt Unit

This block sits next to a real-time clock's timekeeping counter and turns its running BCD time of day into interrupt events. Each time the counter advances it presents a one-cycle seconds tick together with the current BCD seconds, minutes and hours, the one-hot weekday and the BCD day of month. The unit compares these against a programmed alarm and against an update schedule. The schedule is either every second or every minute change.

Each event source has its own sticky flag bit in a flag byte that the host reads. Both sources drive one shared interrupt line that pulses for a single clock. The host clears flags by writing the flag byte. A 0 in a bit position clears that flag and a 1 leaves it alone, so one source can be acknowledged without losing a pending event from the other.

The alarm matches on minute, hour and a third day field. That third field is compared either with the weekday code or with the day of month, chosen by a mode input. When an event source is switched on, the current time is recorded first, so turning a source on never produces an event at once.

Top module: `rtc_event_irq`

## Requirements
- R1: With `upd_en` high and `upd_per_min` low, each evaluated tick (see R7) sets flag bit 5 of `flag_q`.
- R2: With `upd_en` and `upd_per_min` both high, an evaluated tick sets flag bit 5 only when `now_min` differs from the minute recorded at the previous per-minute update event or at enable time. That event then records the new minute.
- R3: In the cycle where `upd_en` or `alm_en` goes from 0 to 1, `now_sec` is recorded as the last evaluated second and any tick is not evaluated. A rise of `upd_en` also records `now_min`. A later tick with an unchanged second produces no event.
- R4: With `alm_en` high, an evaluated tick sets flag bit 3 only when `now_sec` is 8'h00 and `alm_min` equals `now_min` and `alm_hour` equals `now_hour` as whole bytes.
- R5: When `alm_day_sel` is 1, `alm_day` is compared with `now_mday`. When it is 0, `alm_day` is compared with `{1'b0, now_wday}`, where weekday bit 0 is Sunday and bit 6 is Saturday.
- R6: If the update and alarm sources both fire on the same tick, both flags are set and `irq_pulse` is high for one cycle only.
- R7: A tick is evaluated only when `now_sec` differs from the last evaluated second. Repeated ticks carrying the same second cause no event.
- R8: `irq_pulse` goes high in the cycle after the clock edge that samples a firing tick, and stays high for exactly one cycle per firing tick. Flags stay set until the host clears them.
- R9: A `flag_we` cycle ANDs each implemented flag with the matching `flag_wdata` bit. Writing 1 leaves a bit unchanged. Bits other than 5 and 3 always read 0. An event in the same cycle as a write still sets its flag.
- R10: While `rst` is high, `flag_q` is 0 and `irq_pulse` is 0. The first tick after reset is always evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe when the time inputs advance |
| now_sec | input | 8 | Current BCD seconds |
| now_min | input | 8 | Current BCD minutes |
| now_hour | input | 8 | Current BCD hours |
| now_wday | input | 7 | Current one-hot weekday, bit 0 Sunday |
| now_mday | input | 8 | Current BCD day of month |
| alm_min | input | 8 | Alarm minute register |
| alm_hour | input | 8 | Alarm hour register |
| alm_day | input | 8 | Alarm day register (weekday code or day of month) |
| upd_en | input | 1 | Update event enable |
| alm_en | input | 1 | Alarm event enable |
| upd_per_min | input | 1 | 0: update every second, 1: update on minute change |
| alm_day_sel | input | 1 | 0: compare weekday, 1: compare day of month |
| flag_we | input | 1 | Host write strobe for the flag byte |
| flag_wdata | input | 8 | Host write data for the flag byte |
| flag_q | output | 8 | Flag byte: bit 5 update, bit 3 alarm |
| irq_pulse | output | 1 | Single-cycle interrupt pulse |

## Verification
A stale last-seen second shows up within one tick, either as a missing event or as a second `irq_pulse` for a repeated seconds value. A stale recorded minute shows up in per-minute mode as an early or missing flag bit 5 on the first minute change. Mistakes in the alarm comparison show up as flag bit 3 rising in a second other than :00 or under the wrong day mode. The bench compares both outputs against a behavioural model on every clock, so any of these faults is reported in the cycle after the edge where it occurs.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned WDAY_W       = 7;
    localparam int unsigned N_ALM_FIELDS = 3;

    // flag byte positions decoded by host software
    localparam int unsigned FLG_ALM = 3;
    localparam int unsigned FLG_UPD = 5;

    typedef logic [BYTE_W-1:0] reg8_t;
    typedef logic [WDAY_W-1:0] wday_t;

    localparam reg8_t SEC_ZERO  = '0;
    localparam reg8_t SEC_NONE  = '1;
    localparam reg8_t FLAG_IMPL = reg8_t'((1 << FLG_UPD) | (1 << FLG_ALM));

    typedef enum logic {
        DAYSEL_WEEKDAY = 1'b0,
        DAYSEL_MDAY    = 1'b1
    } day_sel_e;

    typedef struct packed {
        reg8_t sec;
        reg8_t min;
        reg8_t hour;
    } tod_t;

    typedef struct packed {
        logic upd;
        logic alm;
    } evt_t;

    typedef struct packed {
        logic     upd_en;
        logic     alm_en;
        logic     per_min;
        day_sel_e day_sel;
    } cfg_t;

    function automatic reg8_t day_key(day_sel_e sel, wday_t wday, reg8_t mday);
        reg8_t k;
        if (sel == DAYSEL_MDAY) k = mday;
        else                    k = {{(BYTE_W-WDAY_W){1'b0}}, wday};
        return k;
    endfunction

    function automatic reg8_t evt_to_flags(evt_t e);
        reg8_t f;
        f          = '0;
        f[FLG_UPD] = e.upd;
        f[FLG_ALM] = e.alm;
        return f;
    endfunction

endpackage

// File: rtl/rtc_sec_gate.sv
module rtc_sec_gate
    import rtc_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sec_tick,
    input  reg8_t cur_sec,
    input  logic  arm,
    output logic  eval
);
    reg8_t last_sec_q;

    always_comb begin
        eval = sec_tick && !arm && (cur_sec != last_sec_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_sec_q <= SEC_NONE;
        end else if (arm || eval) begin
            last_sec_q <= cur_sec;
        end
    end

    // R7: an evaluated second is never evaluated again on the next cycle
    a_r7_repeat_second_quiet: assert property (@(posedge clk) disable iff (rst)
        eval |=> !(eval && (cur_sec == $past(cur_sec))))
        else $error("R7: same seconds value evaluated twice");

endmodule

// File: rtl/rtc_upd_src.sv
module rtc_upd_src
    import rtc_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  eval,
    input  logic  arm_upd,
    input  logic  upd_en,
    input  logic  per_min,
    input  reg8_t cur_min,
    output logic  hit
);
    reg8_t last_min_q;
    logic  min_moved;

    always_comb begin
        min_moved = (cur_min != last_min_q);
        hit       = eval && upd_en && (!per_min || min_moved);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_min_q <= SEC_NONE;
        end else if (arm_upd || (hit && per_min)) begin
            last_min_q <= cur_min;
        end
    end

    // R2: a per-minute event is followed by no event for the same minute
    a_r2_minute_once: assert property (@(posedge clk) disable iff (rst)
        (hit && per_min) |=> !(hit && per_min && (cur_min == $past(cur_min))))
        else $error("R2: minute update repeated");

endmodule

// File: rtl/rtc_alm_match.sv
module rtc_alm_match
    import rtc_irq_pkg::*;
#(
    parameter int unsigned NF = N_ALM_FIELDS
)(
    input  logic  eval,
    input  logic  alm_en,
    input  tod_t  tod,
    input  reg8_t key_day,
    input  reg8_t want_min,
    input  reg8_t want_hour,
    input  reg8_t want_day,
    output logic  hit
);
    reg8_t       have [NF];
    reg8_t       want [NF];
    logic [NF-1:0] eq;

    always_comb begin
        have[0] = tod.min;  want[0] = want_min;
        have[1] = tod.hour; want[1] = want_hour;
        have[2] = key_day;  want[2] = want_day;
    end

    for (genvar i = 0; i < NF; i++) begin : g_field
        assign eq[i] = (have[i] == want[i]);
    end

    assign hit = eval && alm_en && (tod.sec == SEC_ZERO) && (&eq);

endmodule

// File: rtl/rtc_flag_irq.sv
module rtc_flag_irq
    import rtc_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  evt,
    input  logic  flag_we,
    input  reg8_t flag_wdata,
    output reg8_t flags,
    output logic  irq
);
    reg8_t flags_q, keep, nxt;
    logic  irq_q;

    always_comb begin
        keep = flag_we ? flag_wdata : '1;
        nxt  = ((flags_q & keep) | evt_to_flags(evt)) & FLAG_IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= nxt;
            irq_q   <= evt.upd | evt.alm;
        end
    end

    assign flags = flags_q;
    assign irq   = irq_q;

    // R9: writing 0 clears a flag when no event arrives in the same cycle
    a_r9_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (flag_we && !flag_wdata[FLG_UPD] && !evt.upd) |=> !flags_q[FLG_UPD])
        else $error("R9: update flag survived a clearing write");

    // R9: writing 1 keeps a set flag
    a_r9_one_keeps: assert property (@(posedge clk) disable iff (rst)
        (flag_we && flag_wdata[FLG_ALM] && flags_q[FLG_ALM]) |=> flags_q[FLG_ALM])
        else $error("R9: alarm flag lost on a keep write");

endmodule

// File: rtl/rtc_event_irq.sv
module rtc_event_irq
    import rtc_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [6:0] now_wday,
    input  logic [7:0] now_mday,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_day,
    input  logic       upd_en,
    input  logic       alm_en,
    input  logic       upd_per_min,
    input  logic       alm_day_sel,
    input  logic       flag_we,
    input  logic [7:0] flag_wdata,
    output logic [7:0] flag_q,
    output logic       irq_pulse
);
    cfg_t  cfg;
    tod_t  tod;
    evt_t  evt;
    logic  upd_en_q, alm_en_q;
    logic  rise_upd, rise_alm, arm, eval;
    reg8_t key_day;

    always_comb begin
        cfg.upd_en  = upd_en;
        cfg.alm_en  = alm_en;
        cfg.per_min = upd_per_min;
        cfg.day_sel = day_sel_e'(alm_day_sel);
        tod.sec     = now_sec;
        tod.min     = now_min;
        tod.hour    = now_hour;
        key_day     = day_key(cfg.day_sel, now_wday, now_mday);
        rise_upd    = cfg.upd_en && !upd_en_q;
        rise_alm    = cfg.alm_en && !alm_en_q;
        arm         = rise_upd || rise_alm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_en_q <= 1'b0;
            alm_en_q <= 1'b0;
        end else begin
            upd_en_q <= cfg.upd_en;
            alm_en_q <= cfg.alm_en;
        end
    end

    rtc_sec_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .cur_sec  (tod.sec),
        .arm      (arm),
        .eval     (eval)
    );

    rtc_upd_src u_upd (
        .clk      (clk),
        .rst      (rst),
        .eval     (eval),
        .arm_upd  (rise_upd),
        .upd_en   (cfg.upd_en),
        .per_min  (cfg.per_min),
        .cur_min  (tod.min),
        .hit      (evt.upd)
    );

    rtc_alm_match #(.NF(N_ALM_FIELDS)) u_alm (
        .eval      (eval),
        .alm_en    (cfg.alm_en),
        .tod       (tod),
        .key_day   (key_day),
        .want_min  (alm_min),
        .want_hour (alm_hour),
        .want_day  (alm_day),
        .hit       (evt.alm)
    );

    rtc_flag_irq u_flags (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .flag_we    (flag_we),
        .flag_wdata (flag_wdata),
        .flags      (flag_q),
        .irq        (irq_pulse)
    );

    // R4: the alarm flag only rises for an enabled alarm in second :00
    a_r4_alarm_at_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[FLG_ALM]) |-> (($past(now_sec) == SEC_ZERO) && $past(alm_en)))
        else $error("R4: alarm flag rose outside second zero");

    // R1: the update flag only rises while updates are enabled
    a_r1_update_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q[FLG_UPD]) |-> $past(upd_en))
        else $error("R1: update flag rose while disabled");

    // R6: every new flag comes with the shared interrupt pulse
    a_r6_flag_has_pulse: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_q[FLG_UPD]) || $rose(flag_q[FLG_ALM])) |-> irq_pulse)
        else $error("R6: flag rose without interrupt pulse");

    // R3: the cycle an enable rises never yields a pulse on the next edge
    a_r3_enable_quiet: assert property (@(posedge clk) disable iff (rst)
        ((upd_en && !upd_en_q) || (alm_en && !alm_en_q)) |=> !irq_pulse)
        else $error("R3: event on the enabling cycle");

endmodule

// File: tb/sim_rtc_event_irq.sv
module sim_rtc_event_irq;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic [7:0] now_sec = 8'h10, now_min = 8'h05, now_hour = 8'h07;
    logic [6:0] now_wday = 7'b0000100;
    logic [7:0] now_mday = 8'h15;
    logic [7:0] alm_min = 8'h30, alm_hour = 8'h07, alm_day = 8'h04;
    logic       upd_en = 1'b0, alm_en = 1'b0, upd_per_min = 1'b0, alm_day_sel = 1'b0;
    logic       flag_we = 1'b0;
    logic [7:0] flag_wdata = 8'h00;
    logic [7:0] flag_q;
    logic       irq_pulse;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_event_irq u0 (
        .clk(clk), .rst(rst), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_mday(now_mday),
        .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
        .upd_en(upd_en), .alm_en(alm_en), .upd_per_min(upd_per_min),
        .alm_day_sel(alm_day_sel), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .flag_q(flag_q), .irq_pulse(irq_pulse)
    );

    // behavioural reference
    int       m_last_sec, m_last_min;
    bit       m_prev_u, m_prev_a, m_irq;
    bit [7:0] m_flags;

    always @(posedge clk) begin
        bit u, a, ru, ra, dmatch;
        u = 0; a = 0;
        if (rst) begin
            m_last_sec = 255; m_last_min = 255;
            m_prev_u = 0; m_prev_a = 0; m_flags = 0; m_irq = 0;
        end else begin
            ru = upd_en && !m_prev_u;
            ra = alm_en && !m_prev_a;
            if (ru || ra) begin
                m_last_sec = int'(now_sec);
                if (ru) m_last_min = int'(now_min);
            end else if (sec_tick && int'(now_sec) != m_last_sec) begin
                m_last_sec = int'(now_sec);
                if (upd_en) begin
                    if (!upd_per_min) u = 1;
                    else if (int'(now_min) != m_last_min) begin
                        u = 1; m_last_min = int'(now_min);
                    end
                end
                dmatch = alm_day_sel ? (alm_day == now_mday) : (alm_day == {1'b0, now_wday});
                if (alm_en && now_sec == 8'h00 && alm_min == now_min &&
                    alm_hour == now_hour && dmatch) a = 1;
            end
            if (flag_we) m_flags = m_flags & flag_wdata;
            m_flags = (m_flags | {2'b00, u, 1'b0, a, 3'b000}) & 8'h28;
            m_irq = u | a;
            m_prev_u = upd_en; m_prev_a = alm_en;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R8 and all others: cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R8 model flags", int'(flag_q), int'(m_flags));
            chk("R8 model irq", int'(irq_pulse), int'(m_irq));
        end
    end

    task automatic do_tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input bit we = 0, input logic [7:0] wd = 8'h00);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; sec_tick = 1'b1;
        flag_we = we; flag_wdata = wd;
        @(negedge clk);
        sec_tick = 1'b0; flag_we = 1'b0;
    endtask

    task automatic wr_flags(input logic [7:0] d);
        @(negedge clk);
        flag_we = 1'b1; flag_wdata = d;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset flags", int'(flag_q), 0);
        chk("R10 reset irq", int'(irq_pulse), 0);
        rst = 1'b0;

        // update per second, enable latch
        @(negedge clk); upd_en = 1'b1;
        do_tick(8'h10, 8'h05, 8'h07);
        chk("R3 latched second no event", int'(flag_q), 0);
        do_tick(8'h11, 8'h05, 8'h07);
        chk("R1 per-second flag", int'(flag_q), 'h20);
        chk("R8 irq pulse", int'(irq_pulse), 1);
        @(negedge clk);
        chk("R8 irq one cycle", int'(irq_pulse), 0);
        chk("R8 flag sticky", int'(flag_q), 'h20);
        do_tick(8'h11, 8'h05, 8'h07);
        chk("R7 repeated second quiet", int'(irq_pulse), 0);

        // host clear
        wr_flags(8'hFF);
        chk("R9 write one keeps", int'(flag_q), 'h20);
        wr_flags(8'h00);
        chk("R9 write zero clears", int'(flag_q), 0);

        // per minute
        @(negedge clk); upd_per_min = 1'b1;
        do_tick(8'h12, 8'h05, 8'h07);
        chk("R2 same minute no event", int'(flag_q), 0);
        do_tick(8'h13, 8'h06, 8'h07);
        chk("R2 minute change flag", int'(flag_q), 'h20);
        wr_flags(8'h00);
        do_tick(8'h14, 8'h06, 8'h07);
        chk("R2 minute recorded", int'(flag_q), 0);

        // alarm, weekday mode
        @(negedge clk); upd_en = 1'b0; upd_per_min = 1'b0; alm_en = 1'b1;
        do_tick(8'h00, 8'h30, 8'h07);
        chk("R4 R5 weekday alarm", int'(flag_q), 'h08);
        chk("R4 alarm irq", int'(irq_pulse), 1);
        wr_flags(8'h00);
        do_tick(8'h01, 8'h30, 8'h07);
        chk("R4 nonzero second", int'(flag_q), 0);
        do_tick(8'h00, 8'h31, 8'h07);
        chk("R4 minute mismatch", int'(flag_q), 0);
        do_tick(8'h01, 8'h30, 8'h07);
        do_tick(8'h00, 8'h30, 8'h08);
        chk("R4 hour mismatch", int'(flag_q), 0);
        @(negedge clk); now_wday = 7'b0001000;
        do_tick(8'h01, 8'h30, 8'h07);
        do_tick(8'h00, 8'h30, 8'h07);
        chk("R5 weekday mismatch", int'(flag_q), 0);

        // alarm, day-of-month mode
        @(negedge clk); alm_day_sel = 1'b1; alm_day = 8'h15;
        do_tick(8'h01, 8'h30, 8'h07);
        do_tick(8'h00, 8'h30, 8'h07);
        chk("R5 day of month alarm", int'(flag_q), 'h08);
        wr_flags(8'h00);
        @(negedge clk); now_mday = 8'h16;
        do_tick(8'h01, 8'h30, 8'h07);
        do_tick(8'h00, 8'h30, 8'h07);
        chk("R5 day of month mismatch", int'(flag_q), 0);

        // both sources
        @(negedge clk); now_mday = 8'h15; upd_en = 1'b1;
        do_tick(8'h00, 8'h30, 8'h07);
        chk("R3 enable latched second", int'(flag_q), 0);
        do_tick(8'h59, 8'h29, 8'h07);
        chk("R1 update again", int'(flag_q), 'h20);
        wr_flags(8'h00);
        do_tick(8'h00, 8'h30, 8'h07);
        chk("R6 both flags", int'(flag_q), 'h28);
        chk("R6 shared pulse", int'(irq_pulse), 1);
        @(negedge clk);
        chk("R6 single pulse", int'(irq_pulse), 0);

        // event wins over same-cycle clear
        do_tick(8'h01, 8'h30, 8'h07, 1'b1, 8'h00);
        chk("R9 event beats clear", int'(flag_q), 'h20);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule